// File: doc/BRIEF.md
# FP8 Logarithmic Multiply/Divide Unit

This block multiplies or divides two 8-bit floating-point operands without a mantissa multiplier or divider. Each operand's magnitude is turned into a fixed-point base-2 logarithm: the exponent field supplies the integer part and a cheap converter supplies the fraction. That converter only ever chooses between the raw mantissa code `x` and `x+1`. The two logarithms are added for a product or subtracted for a quotient, with the exponent bias corrected once. The fractional part of the result then passes through an inverse converter that only ever chooses between `y` and `y-1`, and the result is packed back into an 8-bit word.

The block is purely combinational and uses no clock. A static parameter picks the format: a 4-bit exponent with a 3-bit mantissa (the default), or a 3-bit exponent with a 4-bit mantissa. A mode input picks multiply or divide per operation. Results that fall outside the representable exponent range are saturated or flushed, and a flag reports which. Subnormal encodings, rounding-mode selection and pipelining are not provided.

Top module: `fp8l_muldiv`

## Requirements
- R1: A word is laid out as sign in bit 7, then the exponent field, then the mantissa field in the low bits. `EXP_W`=4 gives a 3-bit mantissa and bias 7. `EXP_W`=3 gives a 4-bit mantissa and bias 3. A magnitude (bits 6:0) of zero encodes zero. Every other code, including exponent field 0, is read as `2^(e-bias)·(1+x/2^M)`, and no code is reserved.
- R2: The log value of an operand is `{e,x} + d` treated as one unsigned number, so a carry runs into the exponent part. Here `d` = 1 exactly when `round(2^M·log2(1+x/2^M)) = x+1`, and otherwise `d` = 0. With a 3-bit mantissa this is codes 2 to 5. With a 4-bit mantissa it is codes 2 to 14.
- R3: The result fraction `y` (with `M` bits) is converted to `y - d`. Here `d` = 1 exactly when `round(2^M·(2^(y/2^M)-1)) = y-1`. With a 3-bit mantissa this is codes 3 to 6. With a 4-bit mantissa it is codes 2 to 14.
- R4: When `op_div_i`=0, the result log is `r = La + Lb - bias·2^M`. The result exponent is `floor(r/2^M)` and the result mantissa is the R3 conversion of `r mod 2^M`.
- R5: When `op_div_i`=1, the result log is `r = La - Lb + bias·2^M`, where La is the dividend and Lb the divisor. It is split and converted as in R4.
- R6: Result bit 7 is always the XOR of the two operand sign bits, including zero, saturated and flushed results.
- R7: When multiplying with either magnitude zero, or when dividing a zero dividend by a nonzero divisor, the result magnitude is zero and both flags are low.
- R8: Dividing by a zero-magnitude divisor gives magnitude 7'h7F with `ovf_o`=1 and `unf_o`=0, even when the dividend is also zero.
- R9: A result exponent above `2^EXP_W-1` gives magnitude 7'h7F, `ovf_o`=1 and `unf_o`=0.
- R10: A result exponent below 1 gives magnitude zero, `unf_o`=1 and `ovf_o`=0.
- R11: `ovf_o` and `unf_o` are never high together. Both are low for every in-range result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 8 | First operand: multiplicand or dividend |
| b_i | input | 8 | Second operand: multiplier or divisor |
| op_div_i | input | 1 | 0 selects multiply, 1 selects divide |
| res_o | output | 8 | Packed result word |
| ovf_o | output | 1 | Result saturated to the largest magnitude |
| unf_o | output | 1 | Result flushed to zero |

## Verification
The assertions check the properties that hold in every evaluation:
- the sign rule;
- the zero-operand and divide-by-zero outcomes;
- that a raised flag forces the matching saturated or flushed magnitude;
- that the two flags are exclusive;
- that each converter moves its input by at most one step in its own direction.

Whether the converters choose the step for exactly the right codes, and whether the exponent bias and the range limits are applied at exactly the right boundary, can only be shown by the bench. It sweeps every operand pair in both formats and both modes against a model that derives each converter decision from real-valued logarithms.

// File: rtl/fp8l_pkg.sv
package fp8l_pkg;

  typedef enum logic {
    OP_MUL = 1'b0,
    OP_DIV = 1'b1
  } fp8l_op_e;

  // Codes whose nearest log2 step lands one above the raw mantissa (R2)
  function automatic logic [15:0] log_bump_mask(input int man_w);
    logic [15:0] m;
    m = '0;
    if (man_w == 3) begin
      for (int i = 2; i <= 5; i++) m[i] = 1'b1;
    end else begin
      for (int i = 2; i <= 14; i++) m[i] = 1'b1;
    end
    return m;
  endfunction

  // Codes whose nearest exp2 step lands one below the raw fraction (R3)
  function automatic logic [15:0] alog_drop_mask(input int man_w);
    logic [15:0] m;
    m = '0;
    if (man_w == 3) begin
      for (int i = 3; i <= 6; i++) m[i] = 1'b1;
    end else begin
      for (int i = 2; i <= 14; i++) m[i] = 1'b1;
    end
    return m;
  endfunction

  function automatic int fmt_bias(input int exp_w);
    return (1 << (exp_w - 1)) - 1;
  endfunction

endpackage

// File: rtl/fp8l_log_conv.sv
module fp8l_log_conv #(
  parameter int EXP_W = 4,
  parameter int MAN_W = 7 - EXP_W
) (
  input  logic [EXP_W-1:0]       exp_i,
  input  logic [MAN_W-1:0]       frac_i,
  output logic [EXP_W+MAN_W-1:0] log_o
);
  localparam int LW = EXP_W + MAN_W;
  localparam logic [15:0] BUMP = fp8l_pkg::log_bump_mask(MAN_W);

  logic bump;

  always_comb begin
    bump  = BUMP[4'(frac_i)];
    // add on the whole concatenation so a fraction carry reaches the exponent
    log_o = {exp_i, frac_i} + LW'(bump);
  end
endmodule

// File: rtl/fp8l_alog_conv.sv
module fp8l_alog_conv #(
  parameter int MAN_W = 3
) (
  input  logic [MAN_W-1:0] frac_i,
  output logic [MAN_W-1:0] frac_o
);
  localparam logic [15:0] DROP = fp8l_pkg::alog_drop_mask(MAN_W);

  logic drop;

  always_comb begin
    drop   = DROP[4'(frac_i)];
    frac_o = frac_i - MAN_W'(drop);
  end
endmodule

// File: rtl/fp8l_repack.sv
module fp8l_repack #(
  parameter int EXP_W = 4,
  parameter int MAN_W = 7 - EXP_W,
  parameter int SW    = EXP_W + MAN_W + 3
) (
  input  logic                 sign_i,
  input  logic                 zero_i,
  input  logic                 sat_i,
  input  logic signed [SW-1:0] exp_i,
  input  logic [MAN_W-1:0]     frac_i,
  output logic [7:0]           word_o,
  output logic                 ovf_o,
  output logic                 unf_o
);
  localparam logic signed [SW-1:0] EMAX_S = SW'((1 << EXP_W) - 1);
  localparam logic signed [SW-1:0] EMIN_S = SW'(1);

  logic too_big;
  logic too_small;

  always_comb begin
    too_big   = exp_i > EMAX_S;
    too_small = exp_i < EMIN_S;
    word_o    = {sign_i, 7'h00};
    ovf_o     = 1'b0;
    unf_o     = 1'b0;
    if (zero_i) begin
      word_o = {sign_i, 7'h00};
    end else if (sat_i || too_big) begin
      word_o = {sign_i, 7'h7F};
      ovf_o  = 1'b1;
    end else if (too_small) begin
      word_o = {sign_i, 7'h00};
      unf_o  = 1'b1;
    end else begin
      word_o = {sign_i, exp_i[EXP_W-1:0], frac_i};
    end
  end
endmodule

// File: rtl/fp8l_muldiv.sv
module fp8l_muldiv #(
  parameter int EXP_W = 4
) (
  input  logic [7:0] a_i,
  input  logic [7:0] b_i,
  input  logic       op_div_i,
  output logic [7:0] res_o,
  output logic       ovf_o,
  output logic       unf_o
);
  import fp8l_pkg::*;

  localparam int MAN_W = 7 - EXP_W;
  localparam int LW    = EXP_W + MAN_W;
  localparam int SW    = LW + 3;
  localparam int BIAS  = fmt_bias(EXP_W);
  localparam logic signed [SW-1:0] BIAS_SH = SW'(BIAS << MAN_W);

  // named internal events
  logic                 zero_a, zero_b;
  logic                 div_by_zero, zero_res;
  logic                 res_sign;
  logic [LW-1:0]        la_v, lb_v;
  logic signed [SW-1:0] la_s, lb_s, sum_s, exp_s;
  logic [MAN_W-1:0]     fr_raw, fr_cnv;
  fp8l_op_e             op;

  fp8l_log_conv #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_log_a (
    .exp_i (a_i[6:MAN_W]),
    .frac_i(a_i[MAN_W-1:0]),
    .log_o (la_v)
  );

  fp8l_log_conv #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_log_b (
    .exp_i (b_i[6:MAN_W]),
    .frac_i(b_i[MAN_W-1:0]),
    .log_o (lb_v)
  );

  always_comb begin
    op          = fp8l_op_e'(op_div_i);
    zero_a      = a_i[6:0] == 7'h00;
    zero_b      = b_i[6:0] == 7'h00;
    res_sign    = a_i[7] ^ b_i[7];
    div_by_zero = (op == OP_DIV) && zero_b;
    zero_res    = (op == OP_MUL) ? (zero_a || zero_b) : (zero_a && !zero_b);
    la_s        = $signed({3'b000, la_v});
    lb_s        = $signed({3'b000, lb_v});
    if (op == OP_DIV) sum_s = la_s - lb_s + BIAS_SH;
    else              sum_s = la_s + lb_s - BIAS_SH;
    exp_s  = sum_s >>> MAN_W;
    fr_raw = sum_s[MAN_W-1:0];
  end

  fp8l_alog_conv #(.MAN_W(MAN_W)) u_alog (
    .frac_i(fr_raw),
    .frac_o(fr_cnv)
  );

  fp8l_repack #(.EXP_W(EXP_W), .MAN_W(MAN_W), .SW(SW)) u_pack (
    .sign_i(res_sign),
    .zero_i(zero_res),
    .sat_i (div_by_zero),
    .exp_i (exp_s),
    .frac_i(fr_cnv),
    .word_o(res_o),
    .ovf_o (ovf_o),
    .unf_o (unf_o)
  );
endmodule

// File: rtl/fp8l_muldiv_chk.sv
module fp8l_muldiv_chk #(
  parameter int EXP_W = 4,
  parameter int MAN_W = 7 - EXP_W
) (
  input logic [7:0]             a_i,
  input logic [7:0]             b_i,
  input logic                   op_div_i,
  input logic [7:0]             res_o,
  input logic                   ovf_o,
  input logic                   unf_o,
  input logic [EXP_W+MAN_W-1:0] la_v,
  input logic [MAN_W-1:0]       fr_raw,
  input logic [MAN_W-1:0]       fr_cnv
);
  localparam int LW = EXP_W + MAN_W;

  always_comb begin
    // R6
    sign_match_chk: assert (res_o[7] == (a_i[7] ^ b_i[7]))
      else $error("result sign differs from operand sign XOR");
    // R7
    mul_zero_chk: assert (op_div_i || (a_i[6:0] != 7'h00 && b_i[6:0] != 7'h00)
                          || (res_o[6:0] == 7'h00 && !ovf_o && !unf_o))
      else $error("product with zero operand is not a clean zero");
    // R8
    div_zero_chk: assert (!op_div_i || b_i[6:0] != 7'h00 || (res_o[6:0] == 7'h7F && ovf_o))
      else $error("division by zero did not saturate");
    // R9
    ovf_sat_chk: assert (!ovf_o || (res_o[6:0] == 7'h7F && !unf_o))
      else $error("overflow flag without saturated magnitude");
    // R10
    unf_flush_chk: assert (!unf_o || res_o[6:0] == 7'h00)
      else $error("underflow flag without zero magnitude");
    // R11
    flag_excl_chk: assert (!(ovf_o && unf_o))
      else $error("both range flags high");
    // R2
    log_step_chk: assert (LW'(la_v - a_i[6:0]) <= LW'(1))
      else $error("log converter moved more than one step");
    // R3
    alog_step_chk: assert (MAN_W'(fr_raw - fr_cnv) <= MAN_W'(1))
      else $error("antilog converter moved more than one step");
  end
endmodule

bind fp8l_muldiv fp8l_muldiv_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
  .a_i     (a_i),
  .b_i     (b_i),
  .op_div_i(op_div_i),
  .res_o   (res_o),
  .ovf_o   (ovf_o),
  .unf_o   (unf_o),
  .la_v    (la_v),
  .fr_raw  (fr_raw),
  .fr_cnv  (fr_cnv)
);

// File: tb/fp8l_muldiv_tb_top.sv
module fp8l_muldiv_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;   // 250 MHz

  logic [7:0] a_drv = 8'h00;
  logic [7:0] b_drv = 8'h00;
  logic [7:0] res_w [4];
  logic       ovf_w [4];
  logic       unf_w [4];

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;
  int  cyc    = 0;

  // config k: bit1 selects exponent width (0 -> 4, 1 -> 3), bit0 selects divide
  for (genvar k = 0; k < 4; k++) begin : g_cfg
    localparam int EW = (k < 2) ? 4 : 3;
    localparam logic DV = (k % 2) == 1;
    fp8l_muldiv #(.EXP_W(EW)) dut_i (
      .a_i     (a_drv),
      .b_i     (b_drv),
      .op_div_i(DV),
      .res_o   (res_w[k]),
      .ovf_o   (ovf_w[k]),
      .unf_o   (unf_w[k])
    );
  end

  function automatic int rnd(input real v);
    return $rtoi($floor(v + 0.5));
  endfunction

  // R2: nearest log2 step
  function automatic int ref_log(input int x, input int n);
    return rnd($ln(1.0 + real'(x) / real'(n)) / $ln(2.0) * real'(n));
  endfunction

  // R3: nearest exp2 step
  function automatic int ref_alog(input int y, input int n);
    return rnd(($pow(2.0, real'(y) / real'(n)) - 1.0) * real'(n));
  endfunction

  task automatic ref_calc(input int ew, input bit dv, input int a, input int b,
                          output int res, output bit ovf, output bit unf,
                          output string tag);
    int m, n, bias, emax, sgn, ma, mb, la, lb, r;
    m = 7 - ew; n = 1 << m; bias = (1 << (ew - 1)) - 1; emax = (1 << ew) - 1;
    sgn = ((a >> 7) ^ (b >> 7)) & 1;
    ma = a & 127; mb = b & 127;
    ovf = 1'b0; unf = 1'b0;
    if (!dv && (ma == 0 || mb == 0)) begin
      res = sgn << 7; tag = "R7 R6 mul-zero"; return;
    end
    if (dv && mb == 0) begin
      res = (sgn << 7) | 127; ovf = 1'b1; tag = "R8 R6 div-by-zero"; return;
    end
    if (dv && ma == 0) begin
      res = sgn << 7; tag = "R7 R6 zero-dividend"; return;
    end
    la = (ma / n) * n + ref_log(ma % n, n);
    lb = (mb / n) * n + ref_log(mb % n, n);
    r  = dv ? (la - lb + bias * n) : (la + lb - bias * n);
    if (r < n) begin
      res = sgn << 7; unf = 1'b1; tag = "R10 R11 flush"; return;
    end
    if (r / n > emax) begin
      res = (sgn << 7) | 127; ovf = 1'b1; tag = "R9 R11 saturate"; return;
    end
    res = (sgn << 7) | ((r / n) << m) | ref_alog(r % n, n);
    tag = dv ? "R5 R1 R2 R3 R6 R11 quotient" : "R4 R1 R2 R3 R6 R11 product";
  endtask

  task automatic compare_all();
    int  er; bit eo, eu; string tg;
    for (int k = 0; k < 4; k++) begin
      ref_calc((k < 2) ? 4 : 3, (k % 2) == 1, int'(a_drv), int'(b_drv), er, eo, eu, tg);
      checks++;
      if (res_w[k] != 8'(er) || ovf_w[k] != eo || unf_w[k] != eu) begin
        errors++;
        $display("FAIL %s cfg=%0d a=%h b=%h: got res=%h ovf=%b unf=%b, expected res=%h ovf=%b unf=%b",
                 tg, k, a_drv, b_drv, res_w[k], ovf_w[k], unf_w[k], 8'(er), eo, eu);
      end
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  initial begin : watchdog
    wait (cyc > 70000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got cycle=%0d, expected end before 70000", cyc);
      done = 1'b1;
      summary();
    end
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    // reset-state pattern: all-zero operands, every config gives zero or saturation (R7, R8)
    compare_all();
    for (int i = 0; i < 65536; i++) begin
      @(negedge clk);
      a_drv = 8'(i >> 8);
      b_drv = 8'(i);
      #1;
      compare_all();
    end
    done = 1'b1;
    summary();
  end
endmodule